// File: doc/BRIEF.md
# Processor Fault and Reset Controller

This block sits beside a small processor core and turns the fault strobes the core reports into one of three results. It can restart the whole MCU with a fixed-length reset pulse, it can pass an exception request with a cause code back to the core, or it can stop the core with a halt request. There are two fault classes, opcode faults and address faults. Each class has its own disable bit in a core control register, and that bit selects reset or exception. Two configuration conditions reclassify an attempted STOP or HALT as an opcode fault. A service register accepts only two values. A write of any other value restarts the MCU at once.

A cause register records why the last reset happened. It is cleared only by power-on, so boot code can read it after the restart. Decoding instructions, vectoring exceptions and counting watchdog timeouts are done elsewhere.

Top module: `fault_reset_ctrl`

## Requirements
- R1: A write to the service register (`wr_en`=1, `wr_sel`=0) with any value other than 0x55 or 0xAA starts a reset pulse in the next cycle. Writing 0x55 or 0xAA has no visible effect.
- R2: The opcode fault class is made of a generic illegal instruction, a line-A opcode, a line-F opcode and a privilege violation. When the opcode-disable bit is 0, one of these starts a reset. When that bit is 1, it raises `exc_req` for one cycle with codes 2, 3, 4 and 5 in that order.
- R3: An attempted STOP counts as an opcode fault (code 2) only when `cfg_stop_en` and `cfg_wait_en` are both 0. Otherwise it has no effect.
- R4: An attempted HALT counts as an opcode fault (code 2) only when `cfg_dbg_en` is 0. Otherwise it has no effect.
- R5: The address fault class is made of a return-format error, a bus error, an address error and a fault-on-fault. When the address-disable bit is 0, one of these starts a reset. When that bit is 1, the first three raise `exc_req` with codes 6, 7 and 8.
- R6: When the address-disable bit is 1, a fault-on-fault raises `halt_req` for one cycle and does not raise an exception.
- R7: The dedicated ILLEGAL opcode always raises `exc_req` with code 1 and never starts a reset.
- R8: A control write (`wr_en`=1, `wr_sel`=1) loads the opcode-disable bit from data bit 0 and the address-disable bit from data bit 1. Both bits are 0 after power-on. A fault in the same cycle as the write is judged with the old bit values.
- R9: The `rst_out` pulse lasts 16 cycles. While it is high, both disable bits are held at 0, and all writes and faults are ignored.
- R10: `rst_cause` is one-hot: bit 0 power-on, bit 1 opcode fault, bit 2 address fault, bit 3 service write error. Power-on sets it to 0001. Each reset overwrites it, and nothing else clears it.
- R11: In the cycle a reset starts, no exception and no halt is raised. The recorded cause follows the order service error, then address fault, then opcode fault. If several exceptions arrive together, the highest code wins. `exc_cause` reads 0 whenever `exc_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| flt_illegal_op | input | 1 | Dedicated ILLEGAL opcode strobe |
| flt_bad_insn | input | 1 | Generic illegal instruction strobe |
| flt_line_a | input | 1 | Illegal line-A opcode strobe |
| flt_line_f | input | 1 | Illegal line-F opcode strobe |
| flt_priv | input | 1 | Privilege violation strobe |
| try_stop | input | 1 | STOP attempted |
| try_halt | input | 1 | HALT attempted |
| flt_ret_fmt | input | 1 | Return format error strobe |
| flt_bus | input | 1 | Bus error termination strobe |
| flt_addr | input | 1 | Address error strobe |
| flt_double | input | 1 | Fault-on-fault strobe |
| cfg_stop_en | input | 1 | Stop mode enable |
| cfg_wait_en | input | 1 | Wait mode enable |
| cfg_dbg_en | input | 1 | Debug mode enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the service register, 1 selects the control register |
| wr_data | input | 8 | Write data |
| rst_out | output | 1 | MCU reset pulse |
| exc_req | output | 1 | One-cycle exception request |
| exc_cause | output | 4 | Exception code (1 to 8) |
| halt_req | output | 1 | One-cycle halt request |
| rst_cause | output | 4 | One-hot cause of the last reset |

## Verification
Every result is registered once. The decision for inputs held across one rising edge appears on `rst_out`, `exc_req`, `exc_cause`, `halt_req` and `rst_cause` just after that edge. The bench therefore drives inputs on a falling edge, releases them and compares all five outputs on the next falling edge. When a reset is expected, it then counts the falling edges on which `rst_out` stays high and expects sixteen. Its model of the disable bits applies a control write only after the fault decision of the same cycle, and a reset clears the model, in the same way as R8 and R9.

// File: rtl/fault_reset_ctrl.sv
module fault_reset_ctrl #(
  parameter int DW = 8,
  parameter int RST_LEN = 16,
  parameter logic [DW-1:0] SVC_A = 8'h55,
  parameter logic [DW-1:0] SVC_B = 8'hAA
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          flt_illegal_op,
  input  logic          flt_bad_insn,
  input  logic          flt_line_a,
  input  logic          flt_line_f,
  input  logic          flt_priv,
  input  logic          try_stop,
  input  logic          try_halt,
  input  logic          flt_ret_fmt,
  input  logic          flt_bus,
  input  logic          flt_addr,
  input  logic          flt_double,
  input  logic          cfg_stop_en,
  input  logic          cfg_wait_en,
  input  logic          cfg_dbg_en,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic          rst_out,
  output logic          exc_req,
  output logic [3:0]    exc_cause,
  output logic          halt_req,
  output logic [3:0]    rst_cause
);
  localparam int CW = $clog2(RST_LEN + 1);

  logic [CW-1:0] rst_cnt;
  logic ird, ard, busy;
  logic stop_bad, halt_bad, opc_flt, adr_flt, svc_err, rst_go, exc_go;
  logic [8:1] cand;
  logic [3:0] code_nx, cause_nx;

  assign busy     = rst_cnt != '0;
  assign rst_out  = busy;
  assign stop_bad = try_stop && !cfg_stop_en && !cfg_wait_en;
  assign halt_bad = try_halt && !cfg_dbg_en;
  assign opc_flt  = !busy && (flt_bad_insn || flt_line_a || flt_line_f || flt_priv || stop_bad || halt_bad);
  assign adr_flt  = !busy && (flt_ret_fmt || flt_bus || flt_addr || flt_double);
  assign svc_err  = !busy && wr_en && !wr_sel && wr_data != SVC_A && wr_data != SVC_B;
  assign rst_go   = svc_err || (opc_flt && !ird) || (adr_flt && !ard);
  assign cause_nx = svc_err ? 4'b1000 : (adr_flt && !ard) ? 4'b0100 : 4'b0010;

  assign cand = {flt_addr, flt_bus, flt_ret_fmt, flt_priv, flt_line_f, flt_line_a,
                 flt_bad_insn || stop_bad || halt_bad, flt_illegal_op};
  assign exc_go = !busy && !rst_go && (|cand);

  always_comb begin
    code_nx = '0;
    for (int i = 1; i <= 8; i++)
      if (cand[i]) code_nx = 4'(i);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_cnt   <= '0;
      ird       <= 1'b0;
      ard       <= 1'b0;
      exc_req   <= 1'b0;
      exc_cause <= '0;
      halt_req  <= 1'b0;
      rst_cause <= 4'b0001;
    end else begin
      exc_req   <= exc_go;
      exc_cause <= exc_go ? code_nx : 4'd0;
      halt_req  <= !rst_go && adr_flt && flt_double;
      if (rst_go) begin
        rst_cnt   <= CW'(RST_LEN);
        ird       <= 1'b0;
        ard       <= 1'b0;
        rst_cause <= cause_nx;
      end else begin
        if (busy) rst_cnt <= rst_cnt - 1'b1;
        if (!busy && wr_en && wr_sel) {ard, ird} <= wr_data[1:0];
      end
    end
  end

  logic [CW:0] hi_len;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) hi_len <= '0;
    else        hi_len <= rst_out ? hi_len + 1'b1 : '0;
  end

  // R1
  svc_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !wr_sel && wr_data != SVC_A && wr_data != SVC_B && !rst_out) |=> rst_out);

  // R9
  pulse_len_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_out) |-> hi_len == (CW+1)'(RST_LEN));

  // R9
  ctl_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_out |-> (!ird && !ard));

  // R10
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!por_n)
    $countones(rst_cause) == 1);

  // R6
  halt_src_chk: assert property (@(posedge clk) disable iff (!por_n)
    halt_req |-> ($past(flt_double) && !rst_out));

  // R11
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_out) |-> (!exc_req && !halt_req));
endmodule

// File: tb/fault_reset_ctrl_tb.sv
module fault_reset_ctrl_tb;
  logic clk = 1'b0, por_n = 1'b0;
  logic [10:0] fv = '0;
  logic stop_en = 1'b0, wait_en = 1'b0, dbg_en = 1'b0;
  logic we = 1'b0, sel = 1'b0;
  logic [7:0] d = '0;
  logic rst_out, exc_req, halt_req;
  logic [3:0] exc_cause, rst_cause;

  int nchk = 0, nerr = 0;
  logic [1:0] ctl_m = 2'b00;
  logic [3:0] cause_m = 4'b0001;
  bit done = 0;

  always #4 clk = ~clk;

  fault_reset_ctrl u_dut (
    .clk(clk), .por_n(por_n),
    .flt_illegal_op(fv[0]), .flt_bad_insn(fv[1]), .flt_line_a(fv[2]), .flt_line_f(fv[3]),
    .flt_priv(fv[4]), .try_stop(fv[5]), .try_halt(fv[6]), .flt_ret_fmt(fv[7]),
    .flt_bus(fv[8]), .flt_addr(fv[9]), .flt_double(fv[10]),
    .cfg_stop_en(stop_en), .cfg_wait_en(wait_en), .cfg_dbg_en(dbg_en),
    .wr_en(we), .wr_sel(sel), .wr_data(d),
    .rst_out(rst_out), .exc_req(exc_req), .exc_cause(exc_cause),
    .halt_req(halt_req), .rst_cause(rst_cause));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [10:0] f, input logic w, input logic s, input logic [7:0] v);
    logic sb, hb, opc, adr, svc, e_rst, e_halt, e_exc;
    logic [3:0] e_code, e_cause;
    logic [8:1] c;
    int n;
    sb  = f[5] && !stop_en && !wait_en;
    hb  = f[6] && !dbg_en;
    opc = f[1] || f[2] || f[3] || f[4] || sb || hb;
    adr = f[7] || f[8] || f[9] || f[10];
    svc = w && !s && v != 8'h55 && v != 8'hAA;
    e_rst = svc || (opc && !ctl_m[0]) || (adr && !ctl_m[1]);
    e_cause = svc ? 4'b1000 : (adr && !ctl_m[1]) ? 4'b0100 : 4'b0010;
    c = {f[9], f[8], f[7], f[4], f[3], f[2], f[1] || sb || hb, f[0]};
    e_exc = !e_rst && (|c);
    e_code = 0;
    for (int i = 1; i <= 8; i++) if (c[i] && e_exc) e_code = 4'(i);
    e_halt = !e_rst && f[10];
    fv = f; we = w; sel = s; d = v;
    @(negedge clk);
    fv = '0; we = 0; sel = 0; d = '0;
    chk(rst_out == e_rst, "R1/R2/R5 rst_out", rst_out, e_rst);
    chk(exc_req == e_exc, "R2/R7/R11 exc_req", exc_req, e_exc);
    chk(exc_cause == e_code, "R11 exc_cause", exc_cause, e_code);
    chk(halt_req == e_halt, "R6 halt_req", halt_req, e_halt);
    if (e_rst) begin
      cause_m = e_cause;
      ctl_m = 2'b00;
    end else if (w && s) ctl_m = v[1:0];
    chk(rst_cause == cause_m, "R10 rst_cause", rst_cause, cause_m);
    if (e_rst && rst_out) begin
      n = 1;
      while (rst_out && n < 40) begin
        @(negedge clk);
        if (rst_out) n++;
      end
      chk(n == 16, "R9 pulse length", n, 16);
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int n;
    @(negedge clk); @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    chk(rst_cause == 4'b0001, "R10 power-on cause", rst_cause, 1);
    chk(!rst_out && !exc_req && !halt_req, "R9 idle after power-on", rst_out, 0);

    // R2 R3 R4 R5 R6 R7 R8: every single fault against every control and config value
    for (int k = 0; k < 4; k++)
      for (int g = 0; g < 8; g++)
        for (int b = 0; b < 11; b++) begin
          apply('0, 1'b1, 1'b1, 8'(k));
          {stop_en, wait_en, dbg_en} = 3'(g);
          apply(11'(1) << b, 1'b0, 1'b0, 8'h00);
        end

    // R1: every service value
    {stop_en, wait_en, dbg_en} = 3'b000;
    for (int v = 0; v < 256; v++) apply('0, 1'b0, 1'b0, 8'(v));

    // R11: all fault combinations with both disable bits set
    apply('0, 1'b1, 1'b1, 8'h03);
    for (int f = 0; f < 2048; f++) apply(11'(f), 1'b0, 1'b0, 8'h00);

    // R11: opcode exceptions mixed with address resets
    {stop_en, wait_en, dbg_en} = 3'b111;
    for (int f = 0; f < 2048; f++) begin
      if (ctl_m != 2'b01) apply('0, 1'b1, 1'b1, 8'h01);
      apply(11'(f), 1'b0, 1'b0, 8'h00);
    end

    // R11: service error dominates cause
    apply('0, 1'b1, 1'b1, 8'h03);
    apply('0, 1'b1, 1'b1, 8'h00);
    apply(11'h7FF, 1'b1, 1'b0, 8'h12);
    // R8: fault in the same cycle as a control write uses the old bits
    apply(11'h004, 1'b1, 1'b1, 8'h03);

    // R9: writes and faults ignored while the pulse is high
    fv = '0; we = 1; sel = 0; d = 8'h00;
    @(negedge clk);
    fv = 11'h7FF; we = 1; sel = 1; d = 8'h03;
    n = 1;
    while (rst_out && n < 40) begin
      @(negedge clk);
      chk(!exc_req && !halt_req, "R9 no exception during pulse", exc_req, 0);
      if (rst_out) n++;
    end
    fv = '0; we = 0; sel = 0; d = '0;
    chk(n == 16, "R9 pulse length under stimulus", n, 16);
    chk(rst_cause == 4'b1000, "R10 cause kept after pulse", rst_cause, 8);
    cause_m = 4'b1000; ctl_m = 2'b00;
    apply(11'h004, 1'b0, 1'b0, 8'h00);

    // R10: only power-on clears the cause
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    chk(rst_cause == 4'b0001, "R10 cause after power-on", rst_cause, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule